// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder and Register Bank

This block is the digital core behind a two-channel voltage-output converter. It takes one 24-bit command word per cycle from an upstream serial receiver. It keeps two stages of code storage for each channel: a staging register that a write fills, and an active register that drives the converter. It also holds one power-down flag per channel and the state of the reference. The word carries an opcode, a channel selector and a left-justified data field. The block applies the effect on the next clock edge.

Loading a channel's active register always brings that channel out of power-down. The reference keeps a record of which command switched it off. A reference that is off because the external source was chosen stays off until the internal source is chosen again. A reference that is off because of a whole-chip power-down also comes back when any channel is updated. A settling flag covers the warm-up time after a channel leaves power-down. The flag lasts longer when both channels and the reference were off. The reset state is chosen by a parameter.

Top module: `dac_cmd_bank`

## Requirements
- R1: The opcode is cmd_word[23:20] and the channel selector is cmd_word[19:16]. The code is cmd_word[15:16-RES]. The lower bits are ignored. Selector 0 picks channel A, selector 1 picks channel B and selector F picks both. Effects are visible on the cycle after cmd_valid.
- R2: Opcode 0 loads the staging register of each selected channel. It leaves the active codes unchanged.
- R3: Opcode 1 copies the staging register into the active register of each selected channel and clears that channel's power-down flag.
- R4: Opcode 2 loads the staging register of the selected channel. It then loads the active registers of both channels from their staging registers and powers both channels up.
- R5: Opcode 3 loads both the staging and the active register of each selected channel from the data field, and powers that channel up.
- R6: Opcode 4 sets the power-down flag of each selected channel. It ignores the data field and leaves the active codes unchanged.
- R7: Opcode 5 powers down both channels and the reference, so ref_on drops.
- R8: Opcode 6 selects the internal reference (ref_sel=0, ref_on=1). Opcode 7 selects the external reference (ref_sel=1, ref_on=0).
- R9: A reference turned off by opcode 7 returns only through opcode 6. A reference turned off by opcode 5 also returns on opcode 1, 2 or 3.
- R10: An update that powers up a channel whose flag was set raises settle_busy on the next cycle. The flag stays high for SHORT_US*CLK_MHZ cycles, or for LONG_US*CLK_MHZ cycles when both channels and the reference were off. An update of channels that are already on does not raise it.
- R11: Opcodes 8 to F, and any selector other than 0, 1 or F, cause no change of state.
- R12: Reset state set by POR_MODE. Mode 0 gives zero codes with the internal reference. Mode 1 gives mid-scale codes with the internal reference. Mode 2 gives mid-scale codes with the external reference. Mode 3 gives mid-scale codes with the internal reference on and both channels powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word is present this cycle |
| cmd_word | input | 24 | Opcode, channel selector and data field |
| code_a | output | RES | Active code of channel A |
| code_b | output | RES | Active code of channel B |
| chan_off | output | 2 | Power-down flags, bit 0 = A, bit 1 = B |
| ref_on | output | 1 | Internal reference is powered |
| ref_sel | output | 1 | 1 = external reference selected |
| settle_busy | output | 1 | Channel warm-up in progress |

## Verification
The main instance is built with a 12-bit code, reset mode 0 and CLK_MHZ=2. The clock parameter shrinks the warm-up windows to 20 and 24 cycles, so both exact lengths can be counted. A second instance uses 8-bit codes and reset mode 3. It reaches the all-off start state, the mid-scale code 0x80 and dropping of the low data byte. A third instance uses 10-bit codes and reset mode 2, which reaches the external-reference reset and the mid-scale code 0x200.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
   localparam logic [3:0] OP_WR        = 4'h0;
   localparam logic [3:0] OP_UPD       = 4'h1;
   localparam logic [3:0] OP_WR_UPDALL = 4'h2;
   localparam logic [3:0] OP_WR_UPD    = 4'h3;
   localparam logic [3:0] OP_PD        = 4'h4;
   localparam logic [3:0] OP_PD_CHIP   = 4'h5;
   localparam logic [3:0] OP_REF_INT   = 4'h6;
   localparam logic [3:0] OP_REF_EXT   = 4'h7;

   localparam int POR_ZERO    = 0;
   localparam int POR_MID_INT = 1;
   localparam int POR_MID_EXT = 2;
   localparam int POR_MID_OFF = 3;

   typedef struct packed {
      logic       wr;
      logic       upd_sel;
      logic       upd_all;
      logic       pd_sel;
      logic       pd_chip;
      logic       ref_int;
      logic       ref_ext;
      logic [1:0] sel;
   } act_t;
endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
   import dacb_pkg::*;
#(
   parameter int RES = 12
) (
   input  logic           valid,
   input  logic [23:0]    word,
   output act_t           act,
   output logic [RES-1:0] code
);
   logic [3:0] op;
   logic [3:0] addr;
   logic [1:0] sel;

   assign op   = word[23:20];
   assign addr = word[19:16];
   assign code = word[15 -: RES];
   assign sel  = {(addr == 4'h1) || (addr == 4'hF), (addr == 4'h0) || (addr == 4'hF)};

   generate
      if (RES < 16) begin : g_pad
         logic pad_unused;
         assign pad_unused = ^word[15-RES:0];
      end
   endgenerate

   always_comb begin
      act     = '0;
      act.sel = sel;
      if (valid && (sel != 2'b00)) begin
         case (op)
            OP_WR:        act.wr = 1'b1;
            OP_UPD:       act.upd_sel = 1'b1;
            OP_WR_UPDALL: begin act.wr = 1'b1; act.upd_all = 1'b1; end
            OP_WR_UPD:    begin act.wr = 1'b1; act.upd_sel = 1'b1; end
            OP_PD:        act.pd_sel = 1'b1;
            OP_PD_CHIP:   act.pd_chip = 1'b1;
            OP_REF_INT:   act.ref_int = 1'b1;
            OP_REF_EXT:   act.ref_ext = 1'b1;
            default:      ;
         endcase
      end
   end
endmodule

// File: rtl/dacb_chan.sv
module dacb_chan
   import dacb_pkg::*;
#(
   parameter int RES      = 12,
   parameter int POR_MODE = POR_ZERO
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           upd,
   input  logic           pd,
   input  logic [RES-1:0] data,
   output logic [RES-1:0] active,
   output logic           off
);
   localparam logic [RES-1:0] RST_CODE = (POR_MODE == POR_ZERO) ? '0 : {1'b1, {(RES-1){1'b0}}};
   localparam logic           RST_OFF  = (POR_MODE == POR_MID_OFF);

   logic [RES-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= RST_CODE;
         active  <= RST_CODE;
         off     <= RST_OFF;
      end else begin
         if (wr) stage_q <= data;
         if (upd) begin
            active <= wr ? data : stage_q;
            off    <= 1'b0;
         end else if (pd) begin
            off <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dacb_ref.sv
module dacb_ref
   import dacb_pkg::*;
#(
   parameter int POR_MODE = POR_ZERO
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_int,
   input  logic go_ext,
   input  logic chip_down,
   input  logic any_up,
   output logic ref_on,
   output logic ref_sel
);
   logic chip_off_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_sel    <= (POR_MODE == POR_MID_EXT);
         chip_off_q <= 1'b0;
      end else if (go_int) begin
         ref_sel    <= 1'b0;
         chip_off_q <= 1'b0;
      end else if (go_ext) begin
         ref_sel <= 1'b1;
      end else if (chip_down) begin
         chip_off_q <= 1'b1;
      end else if (any_up) begin
         chip_off_q <= 1'b0;
      end
   end

   assign ref_on = !ref_sel && !chip_off_q;
endmodule

// File: rtl/dacb_settle.sv
module dacb_settle #(
   parameter int CLK_MHZ  = 50,
   parameter int SHORT_US = 10,
   parameter int LONG_US  = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_sel,
   output logic busy
);
   localparam int SHORT_N = SHORT_US * CLK_MHZ;
   localparam int LONG_N  = LONG_US * CLK_MHZ;
   localparam int CW      = $clog2(LONG_N + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;

   generate
      if (SHORT_N == LONG_N) begin : g_single
         logic sel_unused;
         assign sel_unused = long_sel;
         assign load_val   = CW'(LONG_N);
      end else begin : g_dual
         assign load_val = long_sel ? CW'(LONG_N) : CW'(SHORT_N);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (start)      cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
   import dacb_pkg::*;
#(
   parameter int RES      = 12,
   parameter int POR_MODE = POR_ZERO,
   parameter int CLK_MHZ  = 50,
   parameter int SHORT_US = 10,
   parameter int LONG_US  = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [23:0]    cmd_word,
   output logic [RES-1:0] code_a,
   output logic [RES-1:0] code_b,
   output logic [1:0]     chan_off,
   output logic           ref_on,
   output logic           ref_sel,
   output logic           settle_busy
);
   localparam int NCH = 2;

   generate
      if (RES < 2 || RES > 16) begin : g_bad_res
         $error("RES must lie in 2..16");
      end
      if (POR_MODE < POR_ZERO || POR_MODE > POR_MID_OFF) begin : g_bad_por
         $error("POR_MODE must lie in 0..3");
      end
      if (CLK_MHZ < 1 || SHORT_US < 1 || LONG_US < SHORT_US) begin : g_bad_time
         $error("settling parameters out of range");
      end
   endgenerate

   act_t           act;
   logic [RES-1:0] data;
   logic [NCH-1:0] upd_vec;
   logic [RES-1:0] code_q [NCH];

   dacb_decode #(.RES(RES)) u_dec (
      .valid (cmd_valid),
      .word  (cmd_word),
      .act   (act),
      .code  (data)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign upd_vec[i] = (act.upd_sel & act.sel[i]) | act.upd_all;
      dacb_chan #(.RES(RES), .POR_MODE(POR_MODE)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (act.wr & act.sel[i]),
         .upd    (upd_vec[i]),
         .pd     ((act.pd_sel & act.sel[i]) | act.pd_chip),
         .data   (data),
         .active (code_q[i]),
         .off    (chan_off[i])
      );
   end

   assign code_a = code_q[0];
   assign code_b = code_q[1];

   dacb_ref #(.POR_MODE(POR_MODE)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_int    (act.ref_int),
      .go_ext    (act.ref_ext),
      .chip_down (act.pd_chip),
      .any_up    (|upd_vec),
      .ref_on    (ref_on),
      .ref_sel   (ref_sel)
   );

   dacb_settle #(.CLK_MHZ(CLK_MHZ), .SHORT_US(SHORT_US), .LONG_US(LONG_US)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (|(upd_vec & chan_off)),
      .long_sel ((&chan_off) & !ref_on),
      .busy     (settle_busy)
   );
endmodule

// File: rtl/dacb_chk.sv
module dacb_chk #(
   parameter int RES = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cmd_valid,
   input logic [23:0]    cmd_word,
   input logic [RES-1:0] code_a,
   input logic [RES-1:0] code_b,
   input logic [1:0]     chan_off,
   input logic           ref_on,
   input logic           ref_sel,
   input logic           settle_busy
);
   logic addr_ok;
   assign addr_ok = (cmd_word[19:16] == 4'h0) || (cmd_word[19:16] == 4'h1) || (cmd_word[19:16] == 4'hF);

   // R2
   write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[23:20] == 4'h0 |=> $stable(code_a) && $stable(code_b));

   // R5
   upd_powers_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[23:16] == 8'h30 |=> !chan_off[0]);

   // R6
   pd_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[23:20] == 4'h4 && addr_ok |=> $stable(code_a) && $stable(code_b));

   // R7
   chip_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[23:20] == 4'h5 && addr_ok |=> chan_off == 2'b11 && !ref_on);

   // R8
   ext_ref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_sel |-> !ref_on);

   // R10
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(settle_busy) |-> $past(cmd_valid));

   // R11
   bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[23] |=> $stable(code_a) && $stable(code_b) && $stable(chan_off)
                                    && $stable(ref_on) && $stable(ref_sel));
endmodule

bind dac_cmd_bank dacb_chk #(.RES(RES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_word    (cmd_word),
   .code_a      (code_a),
   .code_b      (code_b),
   .chan_off    (chan_off),
   .ref_on      (ref_on),
   .ref_sel     (ref_sel),
   .settle_busy (settle_busy)
);

// File: tb/dac_cmd_bank_bench.sv
module dac_cmd_bank_bench;
   localparam int CLK_MHZ = 2;
   localparam int SHORT_N = 10 * CLK_MHZ;
   localparam int LONG_N  = 12 * CLK_MHZ;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        v1 = 1'b0, v2 = 1'b0;
   logic [23:0] w1 = '0, w2 = '0;
   logic [11:0] a1, b1;
   logic [7:0]  a2, b2;
   logic [9:0]  a3, b3;
   logic [1:0]  off1, off2, off3;
   logic        on1, on2, on3, sel1, sel2, sel3, bz1, bz2, bz3;

   int compared = 0;
   int mismatched = 0;

   dac_cmd_bank #(.RES(12), .POR_MODE(0), .CLK_MHZ(CLK_MHZ)) u_dac_cmd_bank (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v1), .cmd_word(w1), .code_a(a1), .code_b(b1),
      .chan_off(off1), .ref_on(on1), .ref_sel(sel1), .settle_busy(bz1));

   dac_cmd_bank #(.RES(8), .POR_MODE(3), .CLK_MHZ(CLK_MHZ)) u_dac_cmd_bank_off (
      .clk(clk), .rst_n(rst_n), .cmd_valid(v2), .cmd_word(w2), .code_a(a2), .code_b(b2),
      .chan_off(off2), .ref_on(on2), .ref_sel(sel2), .settle_busy(bz2));

   dac_cmd_bank #(.RES(10), .POR_MODE(2), .CLK_MHZ(CLK_MHZ)) u_dac_cmd_bank_ext (
      .clk(clk), .rst_n(rst_n), .cmd_valid(1'b0), .cmd_word(24'h0), .code_a(a3), .code_b(b3),
      .chan_off(off3), .ref_on(on3), .ref_sel(sel3), .settle_busy(bz3));

   // row: req, word, code_a, code_b, chan_off, ref_on, ref_sel
   localparam logic [59:0] VEC [16] = '{
      {8'd2,  24'h00ABC0, 12'h000, 12'h000, 2'b00, 1'b1, 1'b0}, // R2 stage A only
      {8'd3,  24'h100000, 12'hABC, 12'h000, 2'b00, 1'b1, 1'b0}, // R3 update A
      {8'd1,  24'h315557, 12'hABC, 12'h555, 2'b00, 1'b1, 1'b0}, // R1 low nibble dropped, R5
      {8'd2,  24'h0F1230, 12'hABC, 12'h555, 2'b00, 1'b1, 1'b0}, // R2 stage both
      {8'd6,  24'h40FFFF, 12'hABC, 12'h555, 2'b01, 1'b1, 1'b0}, // R6 power down A
      {8'd3,  24'h1F0000, 12'h123, 12'h123, 2'b00, 1'b1, 1'b0}, // R3 update both
      {8'd4,  24'h219990, 12'h123, 12'h999, 2'b00, 1'b1, 1'b0}, // R4 write B, update all
      {8'd11, 24'h900000, 12'h123, 12'h999, 2'b00, 1'b1, 1'b0}, // R11 unused opcode
      {8'd11, 24'h057770, 12'h123, 12'h999, 2'b00, 1'b1, 1'b0}, // R11 bad selector
      {8'd11, 24'h1F0000, 12'h123, 12'h999, 2'b00, 1'b1, 1'b0}, // R11 staging untouched
      {8'd8,  24'h700000, 12'h123, 12'h999, 2'b00, 1'b0, 1'b1}, // R8 external
      {8'd9,  24'h304440, 12'h444, 12'h999, 2'b00, 1'b0, 1'b1}, // R9 update keeps ref off
      {8'd8,  24'h600000, 12'h444, 12'h999, 2'b00, 1'b1, 1'b0}, // R8 internal
      {8'd7,  24'h500000, 12'h444, 12'h999, 2'b11, 1'b0, 1'b0}, // R7 chip down
      {8'd9,  24'h002220, 12'h444, 12'h999, 2'b11, 1'b0, 1'b0}, // R9 write does not wake ref
      {8'd9,  24'h110000, 12'h444, 12'h999, 2'b01, 1'b1, 1'b0}  // R9 update wakes ref
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send1(input logic [23:0] w);
      @(negedge clk); v1 = 1'b1; w1 = w;
      @(negedge clk); v1 = 1'b0;
   endtask

   task automatic send2(input logic [23:0] w);
      @(negedge clk); v2 = 1'b1; w2 = w;
      @(negedge clk); v2 = 1'b0;
   endtask

   task automatic busy_len(input logic second, output int n);
      n = 0;
      while ((second ? bz2 : bz1) && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset states
      chk("R12", "mode0 code_a", a1, 0);
      chk("R12", "mode0 code_b", b1, 0);
      chk("R12", "mode0 off", off1, 0);
      chk("R12", "mode0 ref", {on1, sel1, bz1}, 3'b100);
      chk("R12", "mode3 codes", {a2, b2}, 16'h8080);
      chk("R12", "mode3 off", off2, 2'b11);
      chk("R12", "mode3 ref", {on2, sel2}, 2'b10);
      chk("R12", "mode2 codes", {a3, b3}, 20'h80200);
      chk("R12", "mode2 off", off3, 0);
      chk("R12", "mode2 ref", {on3, sel3}, 2'b01);

      for (int i = 0; i < 16; i++) begin
         string r;
         r = $sformatf("R%0d", VEC[i][59:52]);
         send1(VEC[i][51:28]);
         chk(r, $sformatf("row %0d code_a", i), a1, VEC[i][27:16]);
         chk(r, $sformatf("row %0d code_b", i), b1, VEC[i][15:4]);
         chk(r, $sformatf("row %0d off", i), off1, VEC[i][3:2]);
         chk(r, $sformatf("row %0d ref_on", i), on1, VEC[i][1]);
         chk(r, $sformatf("row %0d ref_sel", i), sel1, VEC[i][0]);
      end

      // R10 long window: both channels and reference off
      busy_len(1'b0, n);
      send1(24'h500000);
      send1(24'h100000);
      chk("R3", "A staged 222 now active", a1, 12'h222);
      busy_len(1'b0, n);
      chk("R10", "long settle cycles", n, LONG_N);
      // R10 channel already on: no busy
      send1(24'h100000);
      chk("R10", "no settle when on", bz1, 0);
      // R10 short window: only B off, reference on
      send1(24'h110000);
      busy_len(1'b0, n);
      chk("R10", "short settle cycles", n, SHORT_N);

      // R12 mode3 first update powers up at mid-scale, short window
      send2(24'h1F0000);
      chk("R12", "mode3 after update codes", {a2, b2}, 16'h8080);
      chk("R12", "mode3 after update off", off2, 0);
      busy_len(1'b1, n);
      chk("R10", "mode3 short settle", n, SHORT_N);
      // R1 8-bit code takes the top byte of the data field
      send2(24'h30A5FF);
      chk("R1", "8-bit code", a2, 8'hA5);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule